// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recovery

This block turns an asynchronous serial line into tagged characters. It oversamples the line with a 16x baud enable. It frames each character from a start bit, 5 to 8 data bits sent LSB first, an optional even or odd parity bit and one stop bit. Each completed character goes to a downstream FIFO write port as a single-cycle push. The push carries the right-aligned data and three tags: parity error, framing error and break.

Two error paths have their own recovery behaviour:

- **Framing error.** When the stop bit is sampled low, the receiver reports a framing error. It then assumes that the low level is the start bit of the next character. It confirms that level with a second sample and reads the data bits that follow without waiting for a new falling edge.
- **Break.** When the whole frame was low, the receiver checks whether the line stays low for longer than one full word time. If it does, it pushes exactly one all-zero character marked as a break. Reception does not resume until the line has been high for half a bit time.

Top module: `uart_brk_rx`

## Requirements
- R1: A character is framed with `wlen_i` selecting 5, 6, 7 or 8 data bits (codes 0 to 3), received LSB first and sampled at each bit's midpoint. `data_o` is right-aligned, and its bits above the word length read zero.
- R2: A low level that is no longer low at the midpoint of the start bit is discarded as a glitch. It produces no push, and the next valid character is received normally.
- R3: When `par_en_i` is 1, one parity bit follows the data. It is even parity when `par_odd_i` is 0 (the count of ones over data and parity is even) and odd parity when `par_odd_i` is 1. `par_err_o` is 1 on a mismatch. When `par_en_i` is 0, `par_err_o` is 0.
- R4: A stop bit sampled low sets `frm_err_o` on that character, together with its received data.
- R5: After a framing error on a frame that is not all-zero, the low stop level is taken as the next start bit. It is confirmed by one more 16x sample, and the data bits are then sampled one bit time after the stop midpoint.
- R6: If the line stays low for longer than a word time (16 x (start + data + parity + stop) ticks), exactly one character is pushed, however long the low lasts. That character has data 0, `brk_o`=1, `frm_err_o`=1 and `par_err_o`=0.
- R7: After a break, a new start bit is accepted only once the line has been high for 8 consecutive 16x ticks. Low levels seen before that are ignored.
- R8: An all-zero frame whose low level ends before a word time has elapsed is pushed once, with data 0, `frm_err_o`=1 and `brk_o`=0.
- R9: A character that completes while `fifo_full_i` is 1 is not pushed. Instead, `ovr_o` pulses for one cycle, and `push_o` and `ovr_o` are never high together.
- R10: After reset, `push_o`, `ovr_o`, `data_o` and all three tags are 0.
- R11: `push_o` is high for one clock cycle per character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial data line, idle high |
| tick16_i | input | 1 | Enable pulse at 16 times the baud rate |
| wlen_i | input | 2 | Data bit count minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| fifo_full_i | input | 1 | Downstream FIFO cannot take a character |
| push_o | output | 1 | FIFO write strobe, one cycle per character |
| data_o | output | 8 | Received data, right-aligned |
| par_err_o | output | 1 | Parity error tag |
| frm_err_o | output | 1 | Framing error tag |
| brk_o | output | 1 | Break tag |
| ovr_o | output | 1 | Character dropped because the FIFO was full |

## Verification
The assertions watch the output contract on every cycle:

- the push strobe lasts a single cycle and never coincides with an overrun;
- a push never follows a full FIFO;
- a break character always carries zero data and no parity error;
- the parity tag stays clear when parity is off;
- short words leave their upper data bits clear.

Some behaviour depends on where in the line waveform an event happens, and only the bench's scenarios can show it:

- the resynchronisation that reads a character straight out of a bad stop bit;
- the single break character over a low level three word times long;
- the lockout after a short high level following a break;
- the split between a short all-zero frame and a real break.

// File: rtl/uart_brk_rx_pkg.sv
package uart_brk_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_RESYNC,
    ST_BRK_CHK,
    ST_BRK_REC
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       par_err;
    logic       frm_err;
    logic       brk;
  } rx_char_t;

endpackage

// File: rtl/uart_brk_rx_sync.sv
module uart_brk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[g] <= 1'b1;
      else if (g == 0) ff_q[g] <= d_i;
      else ff_q[g] <= ff_q[(g > 0) ? g-1 : 0];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_brk_rx_zrun.sv
module uart_brk_rx_zrun #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  output logic       brk_o
);
  localparam int MAX_WT = OSR * (DATA_W + 3);
  localparam int RW     = $clog2(MAX_WT + 1);

  logic [RW-1:0] run_q;
  logic [RW-1:0] word_ticks;

  // start + data + parity + stop, in 16x ticks
  assign word_ticks = RW'((int'(wlen_i) + DATA_W - 3 + int'(par_en_i) + 2) * OSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (tick_i) begin
      if (rxd_i) run_q <= '0;
      else if (run_q < RW'(MAX_WT)) run_q <= run_q + 1'b1;
    end
  end

  assign brk_o = (run_q >= word_ticks);
endmodule

// File: rtl/uart_brk_rx_fsm.sv
module uart_brk_rx_fsm
  import uart_brk_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       brk_i,
  output logic       emit_o,
  output rx_char_t   chr_o
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_W) + 1;
  localparam int HALF = OSR / 2;

  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              par_q, par_d;
  logic              zero_q, zero_d;

  logic [BW-1:0]     nbits;
  logic [DATA_W-1:0] aligned;
  logic              perr;
  logic              mid_full, mid_half;

  assign nbits    = BW'(wlen_i) + BW'(DATA_W - 3);
  assign aligned  = shf_q >> (BW'(DATA_W) - nbits);
  assign perr     = par_en_i & (par_q ^ par_odd_i);
  assign mid_full = (cnt_q == CW'(OSR - 1));
  assign mid_half = (cnt_q == CW'(HALF - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    shf_d  = shf_q;
    par_d  = par_q;
    zero_d = zero_q;
    emit_o = 1'b0;
    chr_o  = '0;
    if (tick_i) begin
      unique case (st_q)
        ST_IDLE: if (!rxd_i) begin
          st_d  = ST_START;
          cnt_d = '0;
        end
        ST_START: begin
          if (mid_half) begin
            cnt_d  = '0;
            bit_d  = '0;
            par_d  = 1'b0;
            zero_d = 1'b1;
            st_d   = rxd_i ? ST_IDLE : ST_DATA;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (mid_full) begin
            cnt_d  = '0;
            shf_d  = {rxd_i, shf_q[DATA_W-1:1]};
            par_d  = par_q ^ rxd_i;
            zero_d = zero_q & ~rxd_i;
            if (bit_q == nbits - 1'b1) st_d = par_en_i ? ST_PAR : ST_STOP;
            else bit_d = bit_q + 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_PAR: begin
          if (mid_full) begin
            cnt_d  = '0;
            par_d  = par_q ^ rxd_i;
            zero_d = zero_q & ~rxd_i;
            st_d   = ST_STOP;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (mid_full) begin
            cnt_d = '0;
            if (rxd_i) begin
              emit_o = 1'b1;
              chr_o  = '{data: aligned, par_err: perr, frm_err: 1'b0, brk: 1'b0};
              st_d   = ST_IDLE;
            end else if (zero_q) begin
              st_d = ST_BRK_CHK;
            end else begin
              emit_o = 1'b1;
              chr_o  = '{data: aligned, par_err: perr, frm_err: 1'b1, brk: 1'b0};
              st_d   = ST_RESYNC;
            end
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_RESYNC: begin
          // second sample of the presumed start bit
          if (!rxd_i) begin
            st_d   = ST_DATA;
            cnt_d  = CW'(1);
            bit_d  = '0;
            par_d  = 1'b0;
            zero_d = 1'b1;
          end else st_d = ST_IDLE;
        end
        ST_BRK_CHK: begin
          if (rxd_i) begin
            emit_o = 1'b1;
            chr_o  = '{data: '0, par_err: perr, frm_err: 1'b1, brk: 1'b0};
            st_d   = ST_IDLE;
          end else if (brk_i) begin
            emit_o = 1'b1;
            chr_o  = '{data: '0, par_err: 1'b0, frm_err: 1'b1, brk: 1'b1};
            st_d   = ST_BRK_REC;
            cnt_d  = '0;
          end
        end
        ST_BRK_REC: begin
          if (!rxd_i) cnt_d = '0;
          else if (mid_half) st_d = ST_IDLE;
          else cnt_d = cnt_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      shf_q  <= '0;
      par_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      shf_q  <= shf_d;
      par_q  <= par_d;
      zero_q <= zero_d;
    end
  end
endmodule

// File: rtl/uart_brk_rx_out.sv
module uart_brk_rx_out
  import uart_brk_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     emit_i,
  input  rx_char_t chr_i,
  input  logic     full_i,
  output logic     push_o,
  output logic     ovr_o,
  output rx_char_t chr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o <= 1'b0;
      ovr_o  <= 1'b0;
      chr_o  <= '0;
    end else begin
      push_o <= emit_i & ~full_i;
      ovr_o  <= emit_i & full_i;
      if (emit_i && !full_i) chr_o <= chr_i;
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o,
  output logic              ovr_o
);
  logic     rxd_s;
  logic     brk_run;
  logic     emit;
  rx_char_t chr_d, chr_q;

  uart_brk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_brk_rx_zrun #(.OSR(OSR), .DATA_W(DATA_W)) u_zrun (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16_i),
    .rxd_i   (rxd_s),
    .wlen_i  (wlen_i),
    .par_en_i(par_en_i),
    .brk_o   (brk_run)
  );

  uart_brk_rx_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .rxd_i    (rxd_s),
    .wlen_i   (wlen_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .brk_i    (brk_run),
    .emit_o   (emit),
    .chr_o    (chr_d)
  );

  uart_brk_rx_out u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .emit_i(emit),
    .chr_i (chr_d),
    .full_i(fifo_full_i),
    .push_o(push_o),
    .ovr_o (ovr_o),
    .chr_o (chr_q)
  );

  assign data_o    = chr_q.data;
  assign par_err_o = chr_q.par_err;
  assign frm_err_o = chr_q.frm_err;
  assign brk_o     = chr_q.brk;
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] wlen_i,
  input logic       par_en_i,
  input logic       fifo_full_i,
  input logic       push_o,
  input logic [7:0] data_o,
  input logic       par_err_o,
  input logic       brk_o,
  input logic       ovr_o
);
  // R11
  push_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  // R9
  push_ovr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && ovr_o));

  // R9
  push_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(fifo_full_i));

  // R6
  brk_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && brk_o) |-> (data_o == 8'h00 && !par_err_o));

  // R3
  par_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !par_en_i) |-> !par_err_o);

  // R1
  short_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && wlen_i == 2'd0) |-> (data_o[7:5] == 3'b000));
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wlen_i     (wlen_i),
  .par_en_i   (par_en_i),
  .fifo_full_i(fifo_full_i),
  .push_o     (push_o),
  .data_o     (data_o),
  .par_err_o  (par_err_o),
  .brk_o      (brk_o),
  .ovr_o      (ovr_o)
);

// File: tb/uart_brk_rx_tb_top.sv
`timescale 1ns/1ps
module uart_brk_rx_tb_top;
  localparam int TDIV = 4;
  localparam int NV   = 8;
  // {wlen[12:11], par_en[10], par_odd[9], bad_par[8], data[7:0]}
  localparam logic [NV-1:0][12:0] VEC = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 8'h15},
    {2'd1, 1'b1, 1'b0, 1'b0, 8'h2C},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'h5B},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h81},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'hFF},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'h1F},
    {2'd3, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0, full = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic pen = 1'b0, podd = 1'b0;
  logic push, perr, ferr, brk, ovr;
  logic [7:0] data;
  int tcnt = 0;
  int n_chk = 0, n_fail = 0;
  int n_push = 0, n_ovr = 0;
  logic [7:0] last_d, prev_d;
  logic last_p, last_f, last_b, prev_f;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
    tick <= (tcnt == TDIV-1);
  end

  uart_brk_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick16_i(tick),
    .wlen_i(wlen), .par_en_i(pen), .par_odd_i(podd), .fifo_full_i(full),
    .push_o(push), .data_o(data), .par_err_o(perr), .frm_err_o(ferr),
    .brk_o(brk), .ovr_o(ovr)
  );

  always @(negedge clk) if (rst_n) begin
    if (push) begin
      n_push++;
      prev_d = last_d; prev_f = last_f;
      last_d = data; last_p = perr; last_f = ferr; last_b = brk;
    end
    if (ovr) n_ovr++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input int nt);
    rxd = b;
    repeat (nt * TDIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad, input logic stopv);
    int nb = int'(wlen) + 5;
    logic p = podd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    drive(1'b0, 16);
    for (int i = 0; i < nb; i++) drive(d[i], 16);
    if (pen) drive(p ^ bad, 16);
    drive(stopv, 16);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R10
    chk("R10 push", push, 0); chk("R10 ovr", ovr, 0);
    chk("R10 data", data, 0); chk("R10 tags", {perr, ferr, brk}, 0);
    rst_n = 1'b1;
    drive(1'b1, 20);

    // R1 R3 table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] m;
      wlen = VEC[v][12:11]; pen = VEC[v][10]; podd = VEC[v][9];
      m = 8'((16'd1 << (int'(wlen) + 5)) - 1);
      base = n_push;
      send(VEC[v][7:0], VEC[v][8], 1'b1);
      drive(1'b1, 16);
      chk("R11 one push", n_push - base, 1);
      chk("R1 data", last_d, VEC[v][7:0] & m);
      chk("R3 parity tag", last_p, VEC[v][8] & VEC[v][10]);
      chk("R4 no frame err", last_f, 0);
    end
    wlen = 2'd3; pen = 1'b0; podd = 1'b0;

    // R2 glitch
    base = n_push;
    drive(1'b0, 4); drive(1'b1, 48);
    chk("R2 glitch dropped", n_push - base, 0);
    send(8'h6E, 1'b0, 1'b1); drive(1'b1, 16);
    chk("R2 recv after glitch", last_d, 8'h6E);

    // R4 R5 framing error then resync
    base = n_push;
    send(8'h5A, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive(8'hC3 >> i & 1, 16);
    drive(1'b1, 32);
    chk("R5 two pushes", n_push - base, 2);
    chk("R4 bad char data", prev_d, 8'h5A);
    chk("R4 bad char frm", prev_f, 1);
    chk("R5 resync data", last_d, 8'hC3);
    chk("R5 resync frm", last_f, 0);

    // R8 short all-zero frame
    base = n_push;
    drive(1'b0, 16 + 128 + 10); drive(1'b1, 30);
    chk("R8 one push", n_push - base, 1);
    chk("R8 data", last_d, 0);
    chk("R8 frm", last_f, 1);
    chk("R8 no brk", last_b, 0);

    // R6 R7 long break, short high, low again
    base = n_push;
    drive(1'b0, 480); drive(1'b1, 4); drive(1'b0, 32); drive(1'b1, 32);
    chk("R6 R7 single push", n_push - base, 1);
    chk("R6 brk", last_b, 1);
    chk("R6 data", last_d, 0);
    chk("R6 frm", last_f, 1);
    send(8'h39, 1'b0, 1'b1); drive(1'b1, 16);
    chk("R7 resume", last_d, 8'h39);
    chk("R7 resume brk", last_b, 0);

    // R9 overrun
    base = n_push;
    full = 1'b1;
    send(8'h3C, 1'b0, 1'b1); drive(1'b1, 16);
    chk("R9 no push", n_push - base, 0);
    chk("R9 ovr", n_ovr, 1);
    full = 1'b0;
    send(8'h96, 1'b0, 1'b1); drive(1'b1, 16);
    chk("R9 after full", last_d, 8'h96);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule